// File: doc/BRIEF.md
# Initialization Block Fetch Sequencer

This block copies a fixed table of twelve 16-bit configuration words from system memory into a bank of internal registers. It acts as a bus master. After a start pulse it raises a bus request and waits for the grant. It then reads words from consecutive even byte addresses, beginning at a base address. Each word read is handed to a register write port together with its index. When all twelve words are stored, a single-cycle done pulse follows.

The words arrive in groups of four. By default every group has a bus tenure of its own: the sequencer gives the bus back after each group and asks for it again, so a fetch needs three tenures. An optional activity budget, counted in clock cycles from the grant, lets the sequencer keep the bus across a group boundary. At each boundary it keeps the bus only if the budget still covers another full group. A fetch can therefore finish in one, two or three tenures.

Top module: `init_block_fetch`

## Requirements
- R1: While reset is held and directly after it, `bus_req`, `mem_rd`, `reg_we` and `done` are low.
- R2: `mem_rd` is high only while `bus_gnt` is high.
- R3: Word k of a fetch (k = 0..11) is read from byte address `base_addr + 2*k`. `mem_addr` holds steady while a read waits for `mem_rdy`.
- R4: Each word accepted (`mem_rd` and `mem_rdy` high at a rising edge) gives exactly one `reg_we` pulse in the next cycle. That pulse carries `reg_idx` = k and the data accepted. A fetch produces exactly twelve such writes, with indices 0 to 11 in order.
- R5: With `tmr_en` low at start, the fetch uses exactly three tenures of four words each.
- R6: With `tmr_en` high at start, let n be the number of cycles `mem_rd` has been high in the current tenure, counting the cycle in which the fourth or eighth word of the fetch is accepted. The sequencer keeps reading in the next cycle if n + 4 <= `tmr_limit`. Otherwise it releases the bus. The fetch thus uses one to three tenures.
- R7: In the cycle after the last word of a tenure is accepted, `bus_req` and `mem_rd` are low. A new request follows only after `bus_gnt` has fallen.
- R8: `done` is high for exactly one cycle: the cycle after the `reg_we` pulse with index 11.
- R9: A `start` pulse during a fetch is ignored. The running fetch keeps its base address and its timer settings.
- R10: After a re-grant, reading resumes at the first word not yet accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; every output is synchronous to it |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begins a fetch when the sequencer is idle |
| base_addr | input | 24 | Byte address of word 0, sampled at start |
| tmr_en | input | 1 | Enables merging of groups into one tenure, sampled at start |
| tmr_limit | input | 16 | Activity budget in cycles per tenure, sampled at start |
| bus_req | output | 1 | Bus mastership request |
| bus_gnt | input | 1 | Bus mastership grant |
| mem_rd | output | 1 | Memory read strobe |
| mem_addr | output | 24 | Byte address of the current read |
| mem_rdy | input | 1 | Memory has valid data; the word is accepted at this edge |
| mem_rdata | input | 16 | Read data |
| reg_we | output | 1 | Register write strobe |
| reg_idx | output | 4 | Index of the register being written |
| reg_wdata | output | 16 | Data for the register write |
| done | output | 1 | One-cycle pulse when the fetch is complete |

## Verification
A bad word or group count in the sequencer shows up within one cycle of the affected accept. Either the bus stays requested where it should be released, or the reverse, and the bench checks `bus_req` and `mem_rd` in exactly that cycle. A stale address counter is seen at the very next read, as a wrong `mem_addr`, or as a write with the wrong index or data one cycle later. A wrong budget comparison changes the tenure boundary at the fourth or eighth word. The bench checks runs with the budget just above and just below those points, and runs with random wait states.

// File: rtl/ibf_pkg.sv
// Package: shared state type for the initialization block fetch sequencer.
// Assumes: nothing beyond IEEE 1800-2017.
package ibf_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,   // waiting for start
        ST_REQ  = 2'd1,   // request raised, waiting for grant
        ST_XFER = 2'd2,   // bus owned, reading words
        ST_REL  = 2'd3    // request dropped, waiting for grant to fall
    } ibf_state_t;
endpackage

// File: rtl/ibf_walker.sv
// Module: ibf_walker
// Keeps the fetch position. This is the word index, the word count inside the
// current group, and the byte address of the next word.
// Assumes: load and accept are never high together; the address step is 2 bytes.
module ibf_walker #(
    parameter int ADDR_W = 24,
    parameter int IDX_W  = 4,
    parameter int GRP_W  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [ADDR_W-1:0] base,
    input  logic              accept,
    output logic [ADDR_W-1:0] addr,
    output logic [IDX_W-1:0]  word_idx,
    output logic [GRP_W-1:0]  grp_cnt
);
    // Position registers: load at start, step on every accepted word.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr     <= '0;
            word_idx <= '0;
            grp_cnt  <= '0;
        end else if (load) begin
            addr     <= base;
            word_idx <= '0;
            grp_cnt  <= '0;
        end else if (accept) begin
            addr     <= addr + ADDR_W'(2);
            word_idx <= word_idx + IDX_W'(1);
            grp_cnt  <= grp_cnt + GRP_W'(1);
        end
    end
endmodule

// File: rtl/ibf_tenure_timer.sv
// Module: ibf_tenure_timer
// Counts the cycles spent reading in the current tenure. It reports whether
// the budget still covers one more full group after the current cycle.
// Assumes: clear is high before each tenure; the counter saturates.
module ibf_tenure_timer #(
    parameter int TMR_W = 16,
    parameter int GROUP = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             tick,
    input  logic             enable,
    input  logic [TMR_W-1:0] limit,
    output logic             room_ok
);
    localparam int CW = TMR_W + 2;
    logic [TMR_W-1:0] used;

    // Cycle counter: cleared while requesting, counts reading cycles.
    always_ff @(posedge clk) begin
        if (!rst_n || clear)
            used <= '0;
        else if (tick && used != '1)
            used <= used + TMR_W'(1);
    end

    // Budget test: the current cycle plus one more group must fit.
    always_comb begin
        room_ok = enable &&
                  ((CW'(used) + CW'(GROUP + 1)) <= CW'(limit));
    end
endmodule

// File: rtl/ibf_reg_writer.sv
// Module: ibf_reg_writer
// Registers each accepted word onto the register write port. It pulses done
// one cycle after the final index is written.
// Assumes: accept is high for one cycle per word.
module ibf_reg_writer #(
    parameter int DATA_W = 16,
    parameter int IDX_W  = 4,
    parameter int WORDS  = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              accept,
    input  logic [IDX_W-1:0]  idx_in,
    input  logic [DATA_W-1:0] data_in,
    output logic              reg_we,
    output logic [IDX_W-1:0]  reg_idx,
    output logic [DATA_W-1:0] reg_wdata,
    output logic              done
);
    // Write port stage: one write per accepted word.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            reg_we    <= 1'b0;
            reg_idx   <= '0;
            reg_wdata <= '0;
        end else begin
            reg_we <= accept;
            if (accept) begin
                reg_idx   <= idx_in;
                reg_wdata <= data_in;
            end
        end
    end

    // Completion pulse: follows the write of the last index.
    always_ff @(posedge clk) begin
        if (!rst_n)
            done <= 1'b0;
        else
            done <= reg_we && (reg_idx == IDX_W'(WORDS - 1));
    end
endmodule

// File: rtl/init_block_fetch.sv
// Module: init_block_fetch (top)
// Bus-master sequencer. It fetches WORDS words of DATA_W bits from
// consecutive addresses in groups of GROUP words. It keeps the bus across a
// group boundary only when the activity budget allows.
// Assumes: the grant rises only while the request is high and falls after the
// request falls; WORDS is a multiple of GROUP.
module init_block_fetch #(
    parameter int ADDR_W = 24,
    parameter int DATA_W = 16,
    parameter int TMR_W  = 16,
    parameter int WORDS  = 12,
    parameter int GROUP  = 4
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      start,
    input  logic [ADDR_W-1:0]         base_addr,
    input  logic                      tmr_en,
    input  logic [TMR_W-1:0]          tmr_limit,
    output logic                      bus_req,
    input  logic                      bus_gnt,
    output logic                      mem_rd,
    output logic [ADDR_W-1:0]         mem_addr,
    input  logic                      mem_rdy,
    input  logic [DATA_W-1:0]         mem_rdata,
    output logic                      reg_we,
    output logic [$clog2(WORDS)-1:0]  reg_idx,
    output logic [DATA_W-1:0]         reg_wdata,
    output logic                      done
);
    import ibf_pkg::*;

    localparam int IDX_W = $clog2(WORDS);
    localparam int GRP_W = (GROUP > 1) ? $clog2(GROUP) : 1;

    ibf_state_t       state, state_nx;
    logic             en_q;
    logic [TMR_W-1:0] limit_q;
    logic             fin_q;
    logic             accept, load, room_ok, last_word, at_bound;
    logic [IDX_W-1:0] word_idx;
    logic [GRP_W-1:0] grp_cnt;

    assign load      = (state == ST_IDLE) && start;
    assign accept    = (state == ST_XFER) && mem_rdy;
    assign last_word = (word_idx == IDX_W'(WORDS - 1));
    assign at_bound  = (grp_cnt == GRP_W'(GROUP - 1));
    assign mem_rd    = (state == ST_XFER);
    assign bus_req   = (state == ST_REQ) || (state == ST_XFER);

    ibf_walker #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .GRP_W(GRP_W)) u_walk (
        .clk(clk), .rst_n(rst_n), .load(load), .base(base_addr),
        .accept(accept), .addr(mem_addr), .word_idx(word_idx),
        .grp_cnt(grp_cnt)
    );

    ibf_tenure_timer #(.TMR_W(TMR_W), .GROUP(GROUP)) u_tmr (
        .clk(clk), .rst_n(rst_n), .clear(state == ST_REQ),
        .tick(state == ST_XFER), .enable(en_q), .limit(limit_q),
        .room_ok(room_ok)
    );

    ibf_reg_writer #(.DATA_W(DATA_W), .IDX_W(IDX_W), .WORDS(WORDS)) u_wr (
        .clk(clk), .rst_n(rst_n), .accept(accept), .idx_in(word_idx),
        .data_in(mem_rdata), .reg_we(reg_we), .reg_idx(reg_idx),
        .reg_wdata(reg_wdata), .done(done)
    );

    // Settings capture: timer settings are held for the whole fetch.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q    <= 1'b0;
            limit_q <= '0;
        end else if (load) begin
            en_q    <= tmr_en;
            limit_q <= tmr_limit;
        end
    end

    // Finish flag: marks that the last word has been accepted.
    always_ff @(posedge clk) begin
        if (!rst_n || load)
            fin_q <= 1'b0;
        else if (accept && last_word)
            fin_q <= 1'b1;
    end

    // Next-state logic for the request/transfer/release cycle.
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: if (start) state_nx = ST_REQ;
            ST_REQ:  if (bus_gnt) state_nx = ST_XFER;
            ST_XFER: if (accept && (last_word || (at_bound && !room_ok)))
                         state_nx = ST_REL;
            ST_REL:  if (!bus_gnt) state_nx = fin_q ? ST_IDLE : ST_REQ;
            default: state_nx = ST_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n)
            state <= ST_IDLE;
        else
            state <= state_nx;
    end
endmodule

// File: rtl/ibf_checker.sv
// Module: ibf_checker
// Property checks on the ports of init_block_fetch, attached by bind.
// Assumes: the same reset polarity as the design.
module ibf_checker #(
    parameter int ADDR_W = 24,
    parameter int IDX_W  = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_req,
    input logic              bus_gnt,
    input logic              mem_rd,
    input logic              mem_rdy,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              reg_we,
    input logic              done
);
    AST_RD_HAS_GNT: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd |-> (bus_gnt && bus_req)); // R2
    AST_ADDR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd && !mem_rdy) |=> $stable(mem_addr)); // R3
    AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd && mem_rdy) |=> (mem_addr == $past(mem_addr) + ADDR_W'(2))); // R3
    AST_WRITE_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd && mem_rdy) |=> reg_we); // R4
    AST_NO_STRAY_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_rd || !mem_rdy) |=> !reg_we); // R4
    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R8
    AST_DONE_AFTER_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> $past(reg_we)); // R8
endmodule

bind init_block_fetch ibf_checker #(.ADDR_W(ADDR_W), .IDX_W($clog2(WORDS))) u_chk (
    .clk(clk), .rst_n(rst_n), .bus_req(bus_req), .bus_gnt(bus_gnt),
    .mem_rd(mem_rd), .mem_rdy(mem_rdy), .mem_addr(mem_addr),
    .reg_we(reg_we), .done(done)
);

// File: tb/sim_init_block_fetch.sv
module sim_init_block_fetch;
    localparam int CLK_PERIOD = 10;
    localparam int WDOG_LIMIT = 150000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [23:0] base_addr = '0;
    logic        tmr_en = 1'b0;
    logic [15:0] tmr_limit = '0;
    logic        bus_req, bus_gnt = 1'b0;
    logic        mem_rd, mem_rdy = 1'b0;
    logic [23:0] mem_addr;
    logic [15:0] mem_rdata;
    logic        reg_we, done;
    logic [3:0]  reg_idx;
    logic [15:0] reg_wdata;

    int checks = 0, errors = 0, cyc = 0;
    // run model state
    logic [23:0] base_e;
    bit  en_e, always_rdy, prev_rd, pend_we, pend_done;
    int  lim_e, nxt, burst, used, tenures, pend_bound, dones, gdly;
    logic [15:0] pend_data;
    int  pend_idx;

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [15:0] mem_fn(input logic [23:0] a);
        return 16'(a * 3) ^ 16'hC35A;
    endfunction
    assign mem_rdata = mem_fn(mem_addr);

    init_block_fetch u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .base_addr(base_addr),
        .tmr_en(tmr_en), .tmr_limit(tmr_limit), .bus_req(bus_req),
        .bus_gnt(bus_gnt), .mem_rd(mem_rd), .mem_addr(mem_addr),
        .mem_rdy(mem_rdy), .mem_rdata(mem_rdata), .reg_we(reg_we),
        .reg_idx(reg_idx), .reg_wdata(reg_wdata), .done(done)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // Monitor, arbiter and memory model, all at the falling edge.
    initial begin
        forever begin
            @(negedge clk);
            cyc++;
            if (rst_n) begin
                if (mem_rd && !bus_gnt) check(0, "R2", "read without grant", 1, 0);
                if (pend_we) begin
                    check(reg_we && reg_idx == 4'(pend_idx) && reg_wdata == pend_data,
                          "R4", "register write", {reg_we, reg_idx, reg_wdata},
                          {1'b1, 4'(pend_idx), pend_data});
                end else if (reg_we) check(0, "R4", "stray write", 1, 0);
                if (pend_done) check(done, "R8", "done pulse", done, 1);
                else if (done) check(0, "R8", "stray done", 1, 0);
                if (done) dones++;
                pend_done = reg_we && reg_idx == 4'd11;
                pend_we = 0;
                if (pend_bound == 1) check(mem_rd && bus_req, "R6", "kept bus", mem_rd, 1);
                if (pend_bound == 2) check(!bus_req && !mem_rd, "R7", "released bus", bus_req, 0);
                pend_bound = 0;
                if (mem_rd && !prev_rd) begin tenures++; used = 0; end
                prev_rd = mem_rd;
                if (mem_rd) used++;
                // arbiter
                if (!bus_req) begin bus_gnt <= 1'b0; gdly = $urandom % 4; end
                else if (!bus_gnt) begin
                    if (gdly == 0) bus_gnt <= 1'b1; else gdly--;
                end
                // memory ready for the coming edge
                mem_rdy = always_rdy ? 1'b1 : (($urandom % 3) != 0);
                if (mem_rd && mem_rdy) begin
                    check(mem_addr == base_e + 24'(2 * nxt), "R3 R10", "read address",
                          mem_addr, base_e + 24'(2 * nxt));
                    pend_we = 1; pend_idx = nxt; pend_data = mem_fn(base_e + 24'(2 * nxt));
                    burst++;
                    if (nxt == 11) pend_bound = 2;
                    else if (burst % 4 == 0)
                        pend_bound = (en_e && used + 4 <= lim_e) ? 1 : 2;
                    if (pend_bound == 2) burst = 0;
                    nxt++;
                end
            end
        end
    end

    task automatic run(input logic [23:0] b, input bit en, input int lim,
                       input bit ardy, input int exp_ten, input bit mid_start);
        int d0, t;
        base_e = b; en_e = en; lim_e = lim; always_rdy = ardy;
        nxt = 0; burst = 0; tenures = 0; d0 = dones;
        @(negedge clk);
        base_addr = b; tmr_en = en; tmr_limit = 16'(lim); start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        t = 0;
        while (dones == d0 && t < 2000) begin
            @(negedge clk); t++;
            if (mid_start && t == 9) begin   // R9: ignored while busy
                base_addr = ~b & 24'hFFFFFE; tmr_en = ~en; tmr_limit = 16'hFFFF; start = 1'b1;
            end else start = 1'b0;
        end
        check(nxt == 12, "R4", "words fetched", nxt, 12);
        if (!en) check(tenures == 3, "R5", "tenures with timer off", tenures, 3);
        else check(tenures >= 1 && tenures <= 3, "R6", "tenure range", tenures, 2);
        if (exp_ten > 0) check(tenures == exp_ten, "R6", "tenure count", tenures, exp_ten);
        repeat (3) @(negedge clk);
        check(!bus_req && !mem_rd, "R7", "idle after fetch", bus_req, 0);
    endtask

    initial begin
        void'($urandom(32'h1B2C3D));
        prev_rd = 0; pend_we = 0; pend_done = 0; pend_bound = 0; dones = 0; gdly = 0;
        repeat (3) @(negedge clk);
        check(!bus_req && !mem_rd && !reg_we && !done, "R1", "outputs in reset",
              {bus_req, mem_rd, reg_we, done}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(!bus_req && !mem_rd && !reg_we && !done, "R1", "outputs after reset",
              {bus_req, mem_rd, reg_we, done}, 0);
        // directed corners
        run(24'h001000, 0, 0, 1, 3, 0);       // R5
        run(24'h00FFF8, 0, 100, 0, 3, 0);     // R5 limit ignored
        run(24'h020000, 1, 0, 1, 3, 0);       // R6 no budget
        run(24'h020100, 1, 7, 1, 3, 0);       // R6 one short of merging
        run(24'h020200, 1, 8, 1, 2, 0);       // R6 merge first two groups
        run(24'h020300, 1, 11, 1, 2, 0);      // R6 one short of full merge
        run(24'h020400, 1, 12, 1, 1, 0);      // R6 single tenure
        run(24'h030000, 1, 65535, 0, 1, 0);   // R6 large budget
        run(24'h040000, 0, 0, 0, 3, 1);       // R9 start while busy
        run(24'h050000, 1, 5, 0, 0, 1);       // R9 with timer
        // constrained random runs
        for (int i = 0; i < 24; i++) begin
            run(24'($urandom) & 24'hFFFFFE, 1'($urandom), $urandom % 40,
                1'($urandom % 4 == 0), 0, 0);
        end
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    // Watchdog.
    initial begin
        wait (cyc > WDOG_LIMIT);
        check(0, "R4", "watchdog expired", cyc, WDOG_LIMIT);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule